// File: doc/BRIEF.md
# Processor trap and status controller

This block holds the privileged state of a simple in-order core: a status word (trap enable, current and saved supervisor bits, two 64-bit enable bits and an interrupt mask) and a cause word (exception code and an interrupt-pending field). Each cycle it combines the pending field with the mask and decides whether to take an interrupt. If no interrupt is taken, it accepts a synchronous trap request from the pipeline. On a trap it updates status and cause in one edge and latches the faulting address reported by the memory unit.

A retire-driven cycle counter compares against a software-written compare value and raises the timer interrupt in the pending field. A trap request that arrives while traps are disabled, or that carries an unsupported number, is not nested. It sets a sticky error-mode flag, which stays set until reset and blocks every later trap. The block also reports the effective integer register width for the current privilege mode.

Top module: `trap_status_ctrl`

## Requirements
- R1: After reset, status reads 0x0012 (supervisor bit and supervisor 64-bit bit set), cause reads 0, the captured address reads 0, error mode is low and the width reads 64.
- R2: Status layout: bit 0 trap enable, bit 1 supervisor, bit 2 saved supervisor, bit 3 user 64-bit, bit 4 supervisor 64-bit, bits 15:8 interrupt mask. Cause layout: bits 4:0 exception code, bits 15:8 interrupt pending. `take_trap` rises in the same cycle as the request, with no register delay, when (pending AND mask) is nonzero and trap enable is 1.
- R3: On the edge that ends a `take_trap` cycle, trap enable clears, supervisor sets, saved supervisor takes the old supervisor bit, and all other status bits keep their values.
- R4: On that edge the cause code becomes the trap number, or 19 for an interrupt. The pending field is preserved.
- R5: The captured address loads `bad_addr` on the trap-entry edge and holds its value on every other edge.
- R6: A synchronous request made with trap enable clear, or with a trap number of 20 or more, takes no trap and leaves status and cause unchanged. It sets `error_mode`, which stays set until reset.
- R7: An interrupt and a synchronous request in the same cycle take the interrupt (code 19). The request is dropped and does not set error mode.
- R8: The counter increments once per `retire`. When a retire sees the counter equal to the compare value, pending bit 7 (cause bit 15) sets on that edge.
- R9: The width output is 64 when the active mode's 64-bit bit is set (bit 4 in supervisor mode, bit 3 otherwise) and 32 otherwise.
- R10: With the 64-bit option off, both 64-bit bits are forced to 0, both at reset and on writes. Status then resets to 0x0002 and the width is always 32.
- R11: A status write keeps only the defined bits, so undefined bits read 0. A trap entry in the same cycle overrides the write. A pending write replaces the pending field.
- R12: While error mode is set, neither interrupts nor synchronous requests are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Synchronous trap request |
| trap_num | input | 5 | Trap number of the request |
| bad_addr | input | ADDR_W | Faulting address reported by the memory unit |
| sr_we | input | 1 | Status write strobe |
| sr_wdata | input | 16 | Status write value |
| cmp_we | input | 1 | Compare write strobe |
| cmp_wdata | input | CNT_W | Compare write value |
| ip_we | input | 1 | Pending-field write strobe |
| ip_wdata | input | 8 | Pending-field write value |
| retire | input | 1 | One instruction retired |
| take_trap | output | 1 | Trap entered on this cycle's edge |
| status | output | 16 | Status word |
| cause | output | 16 | Cause word |
| badvaddr | output | ADDR_W | Captured faulting address |
| reg_width | output | 7 | Effective register width, 32 or 64 |
| error_mode | output | 1 | Sticky error mode |

## Verification
The bound checker covers the properties that hold on every cycle. These are: the trap-entry update of status and cause, the address capture and its hold, the stickiness of error mode, no trap while it is set or while trap enable is clear, and the width staying at 32 or 64. The bench scenarios cover the behaviour that depends on a sequence of events. These are: priority between simultaneous requests, error entry on a bad number, masking of undefined status bits, a write losing to a trap, the counter reaching compare only on the right retire, and the forced-off 64-bit variant.

// File: rtl/trap_pkg.sv
package trap_pkg;
   localparam int SR_W      = 16;
   localparam int CAUSE_W   = 16;
   localparam int ET_B      = 0;
   localparam int S_B       = 1;
   localparam int PS_B      = 2;
   localparam int UX_B      = 3;
   localparam int SX_B      = 4;
   localparam int IM_LSB    = 8;
   localparam int PEND_W    = 8;
   localparam int CODE_W    = 5;
   localparam int IP_LSB    = 8;
   localparam int TIMER_IDX = 7;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
#(
   parameter int NUM_TRAPS = 20,
   parameter int IRQ_CODE  = 19
) (
   input  logic              trap_en,
   input  logic              err_now,
   input  logic [PEND_W-1:0] pend,
   input  logic [PEND_W-1:0] mask,
   input  logic              trap_req,
   input  logic [CODE_W-1:0] trap_num,
   output logic              take,
   output logic [CODE_W-1:0] code,
   output logic              err_set
);
   logic irq_go, num_ok, sync_go;

   always_comb begin
      irq_go  = (|(pend & mask)) && trap_en && !err_now;
      num_ok  = 32'(trap_num) < NUM_TRAPS;
      sync_go = trap_req && !irq_go && trap_en && num_ok && !err_now;
      err_set = trap_req && !irq_go && !err_now && (!trap_en || !num_ok);
      take    = irq_go || sync_go;
      code    = irq_go ? CODE_W'(IRQ_CODE) : trap_num;
   end
endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg
   import trap_pkg::*;
#(
   parameter bit HAS_64 = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic            sr_we,
   input  logic [SR_W-1:0] sr_wdata,
   output logic [SR_W-1:0] status,
   output logic [6:0]      reg_width
);
   localparam logic [SR_W-1:0] BASE_MASK =
      SR_W'((1 << ET_B) | (1 << S_B) | (1 << PS_B)) | (SR_W'((1 << PEND_W) - 1) << IM_LSB);
   localparam logic [SR_W-1:0] WIDE_BITS = SR_W'((1 << UX_B) | (1 << SX_B));

   logic [SR_W-1:0] wmask;
   logic [SR_W-1:0] rst_val;
   logic [SR_W-1:0] entry;
   logic            wide;

   generate
      if (HAS_64) begin : g_wide
         assign wmask = BASE_MASK | WIDE_BITS;
      end else begin : g_narrow
         assign wmask = BASE_MASK;
      end
   endgenerate

   assign rst_val = SR_W'((1 << S_B) | (1 << SX_B)) & wmask;

   always_comb begin
      entry       = status;
      entry[ET_B] = 1'b0;
      entry[S_B]  = 1'b1;
      entry[PS_B] = status[S_B];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     status <= rst_val;
      else if (take)  status <= entry;
      else if (sr_we) status <= sr_wdata & wmask;
   end

   assign wide      = status[S_B] ? status[SX_B] : status[UX_B];
   assign reg_width = wide ? 7'd64 : 7'd32;
endmodule

// File: rtl/trap_cause_timer.sv
module trap_cause_timer
   import trap_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [CODE_W-1:0]  code,
   input  logic               ip_we,
   input  logic [PEND_W-1:0]  ip_wdata,
   input  logic               cmp_we,
   input  logic [CNT_W-1:0]   cmp_wdata,
   input  logic               retire,
   output logic [CAUSE_W-1:0] cause
);
   logic [CODE_W-1:0] code_q;
   logic [PEND_W-1:0] pend_q, pend_d;
   logic [CNT_W-1:0]  cnt_q, cmp_q;
   logic              hit;

   assign hit = retire && (cnt_q == cmp_q);

   always_comb begin
      pend_d = ip_we ? ip_wdata : pend_q;
      if (hit) pend_d[TIMER_IDX] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         pend_q <= '0;
         cnt_q  <= '0;
         cmp_q  <= '0;
      end else begin
         pend_q <= pend_d;
         if (take)   code_q <= code;
         if (retire) cnt_q  <= cnt_q + 1'b1;
         if (cmp_we) cmp_q  <= cmp_wdata;
      end
   end

   always_comb begin
      cause                      = '0;
      cause[CODE_W-1:0]          = code_q;
      cause[IP_LSB +: PEND_W]    = pend_q;
   end
endmodule

// File: rtl/trap_status_ctrl.sv
module trap_status_ctrl
   import trap_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int CNT_W     = 32,
   parameter int NUM_TRAPS = 20,
   parameter int IRQ_CODE  = 19,
   parameter bit HAS_64    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trap_req,
   input  logic [4:0]         trap_num,
   input  logic [ADDR_W-1:0]  bad_addr,
   input  logic               sr_we,
   input  logic [15:0]        sr_wdata,
   input  logic               cmp_we,
   input  logic [CNT_W-1:0]   cmp_wdata,
   input  logic               ip_we,
   input  logic [7:0]         ip_wdata,
   input  logic               retire,
   output logic               take_trap,
   output logic [15:0]        status,
   output logic [15:0]        cause,
   output logic [ADDR_W-1:0]  badvaddr,
   output logic [6:0]         reg_width,
   output logic               error_mode
);
   generate
      if (IRQ_CODE >= NUM_TRAPS) begin : g_bad_irq
         $error("IRQ_CODE must be below NUM_TRAPS");
      end
      if (NUM_TRAPS > (1 << CODE_W)) begin : g_bad_num
         $error("NUM_TRAPS exceeds the exception-code range");
      end
      if (SR_W != 16 || CAUSE_W != 16 || CODE_W != 5 || PEND_W != 8) begin : g_bad_pkg
         $error("package layout does not match the port widths");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   logic              err_set;

   trap_arbiter #(.NUM_TRAPS(NUM_TRAPS), .IRQ_CODE(IRQ_CODE)) u_arb (
      .trap_en  (status[ET_B]),
      .err_now  (error_mode),
      .pend     (cause[IP_LSB +: PEND_W]),
      .mask     (status[IM_LSB +: PEND_W]),
      .trap_req (trap_req),
      .trap_num (trap_num),
      .take     (take_trap),
      .code     (code),
      .err_set  (err_set)
   );

   trap_status_reg #(.HAS_64(HAS_64)) u_sr (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take_trap),
      .sr_we     (sr_we),
      .sr_wdata  (sr_wdata),
      .status    (status),
      .reg_width (reg_width)
   );

   trap_cause_timer #(.CNT_W(CNT_W)) u_ct (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take_trap),
      .code      (code),
      .ip_we     (ip_we),
      .ip_wdata  (ip_wdata),
      .cmp_we    (cmp_we),
      .cmp_wdata (cmp_wdata),
      .retire    (retire),
      .cause     (cause)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         badvaddr   <= '0;
         error_mode <= 1'b0;
      end else begin
         if (take_trap) badvaddr   <= bad_addr;
         if (err_set)   error_mode <= 1'b1;
      end
   end
endmodule

// File: rtl/trap_status_chk.sv
module trap_status_chk
   import trap_pkg::*;
#(
   parameter int ADDR_W   = 64,
   parameter int IRQ_CODE = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        trap_num,
   input logic [ADDR_W-1:0] bad_addr,
   input logic              take_trap,
   input logic [15:0]       status,
   input logic [15:0]       cause,
   input logic [ADDR_W-1:0] badvaddr,
   input logic [6:0]        reg_width,
   input logic              error_mode
);
   logic irq_now;
   assign irq_now = |(cause[IP_LSB +: PEND_W] & status[IM_LSB +: PEND_W]);

   // R3
   entry_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> (!status[ET_B] && status[S_B] && status[PS_B] == $past(status[S_B])));

   // R4
   entry_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> cause[CODE_W-1:0] ==
         ($past(irq_now) ? CODE_W'(IRQ_CODE) : $past(trap_num)));

   // R4
   entry_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> cause[IP_LSB +: PEND_W] != 8'h00 || !$past(irq_now));

   // R5
   addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take_trap |=> badvaddr == $past(bad_addr));

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take_trap |=> $stable(badvaddr));

   // R6
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error_mode |=> error_mode);

   // R12
   err_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error_mode |-> !take_trap);

   // R2
   no_take_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status[ET_B] |-> !take_trap);

   // R9
   width_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_width == 7'd32 || reg_width == 7'd64);
endmodule

bind trap_status_ctrl trap_status_chk #(.ADDR_W(ADDR_W), .IRQ_CODE(IRQ_CODE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .trap_num   (trap_num),
   .bad_addr   (bad_addr),
   .take_trap  (take_trap),
   .status     (status),
   .cause      (cause),
   .badvaddr   (badvaddr),
   .reg_width  (reg_width),
   .error_mode (error_mode)
);

// File: tb/trap_status_ctrl_tb.sv
`timescale 1ns/1ps
module trap_status_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trap_req = 1'b0;
   logic [4:0]  trap_num = '0;
   logic [63:0] bad_addr = '0;
   logic        sr_we = 1'b0;
   logic [15:0] sr_wdata = '0;
   logic        cmp_we = 1'b0;
   logic [31:0] cmp_wdata = '0;
   logic        ip_we = 1'b0;
   logic [7:0]  ip_wdata = '0;
   logic        retire = 1'b0;

   logic        take_trap, error_mode, take_n, err_n;
   logic [15:0] status, cause, status_n, cause_n;
   logic [63:0] badvaddr, badvaddr_n;
   logic [6:0]  reg_width, width_n;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   trap_status_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_num(trap_num),
      .bad_addr(bad_addr), .sr_we(sr_we), .sr_wdata(sr_wdata), .cmp_we(cmp_we),
      .cmp_wdata(cmp_wdata), .ip_we(ip_we), .ip_wdata(ip_wdata), .retire(retire),
      .take_trap(take_trap), .status(status), .cause(cause), .badvaddr(badvaddr),
      .reg_width(reg_width), .error_mode(error_mode)
   );

   trap_status_ctrl #(.HAS_64(1'b0)) u_dut_n64 (
      .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_num(trap_num),
      .bad_addr(bad_addr), .sr_we(sr_we), .sr_wdata(sr_wdata), .cmp_we(cmp_we),
      .cmp_wdata(cmp_wdata), .ip_we(ip_we), .ip_wdata(ip_wdata), .retire(retire),
      .take_trap(take_n), .status(status_n), .cause(cause_n), .badvaddr(badvaddr_n),
      .reg_width(width_n), .error_mode(err_n)
   );

   // {sr_wdata, ip_wdata, req, num, exp_take, exp_status, exp_cause, exp_err}
   localparam int NV = 10;
   localparam logic [63:0] VEC [NV] = '{
      {16'h0003, 8'h00, 1'b1, 5'd5,  1'b1, 16'h0006, 16'h0005, 1'b0}, // R3 R4 supervisor
      {16'h0001, 8'h00, 1'b1, 5'd7,  1'b1, 16'h0002, 16'h0007, 1'b0}, // R3 from user
      {16'hFF19, 8'h04, 1'b0, 5'd0,  1'b1, 16'hFF1A, 16'h0413, 1'b0}, // R2 R4 interrupt
      {16'h0F03, 8'hF0, 1'b1, 5'd2,  1'b1, 16'h0F06, 16'hF002, 1'b0}, // R2 masked, R4 keep pend
      {16'h0002, 8'h00, 1'b1, 5'd3,  1'b0, 16'h0002, 16'h0000, 1'b1}, // R6 disabled
      {16'h0003, 8'h00, 1'b1, 5'd20, 1'b0, 16'h0003, 16'h0000, 1'b1}, // R6 bad number
      {16'h0103, 8'h01, 1'b1, 5'd4,  1'b1, 16'h0106, 16'h0113, 1'b0}, // R7 priority
      {16'h0102, 8'h01, 1'b0, 5'd0,  1'b0, 16'h0102, 16'h0100, 1'b0}, // R2 no ET
      {16'h0003, 8'h00, 1'b1, 5'd19, 1'b1, 16'h0006, 16'h0013, 1'b0}, // R6 top legal number
      {16'hFFFF, 8'h00, 1'b0, 5'd0,  1'b0, 16'hFF1F, 16'h0000, 1'b0}  // R11 masking
   };

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      trap_req = 1'b0; sr_we = 1'b0; ip_we = 1'b0; cmp_we = 1'b0; retire = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      #1;
      // R1 reset values
      check("R1 status", 64'(status), 64'h0012);
      check("R1 cause", 64'(cause), 64'h0);
      check("R1 badvaddr", badvaddr, 64'h0);
      check("R1 error", 64'(error_mode), 64'h0);
      check("R1 width", 64'(reg_width), 64'd64);
      // R10 reset of forced-narrow variant
      check("R10 status", 64'(status_n), 64'h0002);
      check("R10 width", 64'(width_n), 64'd32);

      for (int i = 0; i < NV; i++) begin
         logic [63:0] v;
         logic [63:0] addr;
         v = VEC[i];
         addr = {32'hDEAD0000, 32'(i + 1) << 4};
         do_reset();
         @(negedge clk);
         sr_we = 1'b1; sr_wdata = v[63:48];
         ip_we = 1'b1; ip_wdata = v[47:40];
         @(negedge clk);
         sr_we = 1'b0; ip_we = 1'b0;
         trap_req = v[39]; trap_num = v[38:34]; bad_addr = addr;
         #1;
         check($sformatf("R2 R7 take vec%0d", i), 64'(take_trap), 64'(v[33]));
         @(posedge clk); #1;
         check($sformatf("R3 status vec%0d", i), 64'(status), 64'(v[32:17]));
         check($sformatf("R4 cause vec%0d", i), 64'(cause), 64'(v[16:1]));
         check($sformatf("R6 error vec%0d", i), 64'(error_mode), 64'(v[0]));
         check($sformatf("R5 addr vec%0d", i), badvaddr, v[33] ? addr : 64'h0);
         @(negedge clk);
         trap_req = 1'b0;
      end

      // R12: error mode blocks a later interrupt
      do_reset();
      @(negedge clk); trap_req = 1'b1; trap_num = 5'd3;
      @(negedge clk); trap_req = 1'b0;
      sr_we = 1'b1; sr_wdata = 16'h0103; ip_we = 1'b1; ip_wdata = 8'h01;
      @(negedge clk); sr_we = 1'b0; ip_we = 1'b0;
      #1;
      check("R12 take blocked", 64'(take_trap), 64'h0);
      @(posedge clk); #1;
      check("R12 status kept", 64'(status), 64'h0103);
      check("R6 error sticky", 64'(error_mode), 64'h1);

      // R11: trap entry beats a same-cycle status write
      do_reset();
      @(negedge clk); sr_we = 1'b1; sr_wdata = 16'h0003;
      @(negedge clk); sr_wdata = 16'h00FF; trap_req = 1'b1; trap_num = 5'd1;
      @(posedge clk); #1;
      check("R11 trap over write", 64'(status), 64'h0006);
      @(negedge clk); sr_we = 1'b0; trap_req = 1'b0;

      // R9 width per mode; R10 narrow variant
      do_reset();
      @(negedge clk); sr_we = 1'b1; sr_wdata = 16'h000A;
      @(negedge clk); #1;
      check("R9 sup no SX", 64'(reg_width), 64'd32);
      sr_wdata = 16'h0008;
      @(negedge clk); #1;
      check("R9 user UX", 64'(reg_width), 64'd64);
      sr_wdata = 16'h0010;
      @(negedge clk); #1;
      check("R9 user SX only", 64'(reg_width), 64'd32);
      sr_wdata = 16'h001A;
      @(negedge clk); #1;
      check("R9 sup SX", 64'(reg_width), 64'd64);
      check("R10 forced bits", 64'(status_n), 64'h0002);
      check("R10 forced width", 64'(width_n), 64'd32);
      sr_we = 1'b0;

      // R8 timer compare
      do_reset();
      @(negedge clk); cmp_we = 1'b1; cmp_wdata = 32'd3;
      @(negedge clk); cmp_we = 1'b0; retire = 1'b1;
      repeat (3) @(negedge clk);
      retire = 1'b0; #1;
      check("R8 before compare", 64'(cause[15]), 64'h0);
      @(negedge clk); retire = 1'b1;
      @(negedge clk); retire = 1'b0; #1;
      check("R8 compare hit", 64'(cause), 64'h8000);

      // R11 pending write replaces the field
      @(negedge clk); ip_we = 1'b1; ip_wdata = 8'h21;
      @(negedge clk); ip_we = 1'b0; #1;
      check("R11 pend write", 64'(cause), 64'h2100);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule